// File: doc/BRIEF.md
# Multiplexed External Memory Bus Interface

This block sits between an on-chip requester and an external memory or peripheral bus whose data pins also carry address bits for part of each cycle. It accepts one read or write request at a time, with a 24-bit address, up to 16 bits of data and a byte or word size. It then runs the external cycle: a one-clock address phase with the latch strobe high, followed by a data phase with a read or write strobe. When the data phase ends it returns a one-clock completion pulse and, for reads, the captured data.

Two static configuration inputs select one of four connection models. One chooses the external data width (8 or 16 bits). The other chooses the reachable space (64 Kbytes or 16 Mbytes). The model fixes which upper address bytes travel over the data pins while the strobe is high, so an external transparent latch can hold them. On an 8-bit bus a word request runs as two byte cycles. On a 16-bit bus a byte request uses only the byte lane that matches the address parity.

Top module: `xbus_mux_if`

## Requirements
- R1: The model is selected by {cfg_wide, cfg_big}: 00 gives an 8-bit bus with a 64 KB space, 01 an 8-bit bus with a 16 MB space, 10 a 16-bit bus with a 64 KB space, and 11 a 16-bit bus with a 16 MB space.
- R2: While pad_ale is high, the data pins carry the multiplexed address. Model 00 enables no lane. Model 01 puts A16–A23 on lane 0 (bits 7:0). Model 10 puts A8–A15 on lane 0. Model 11 puts A8–A15 on lane 0 and A16–A23 on lane 1 (bits 15:8). pad_dq_oe bit i enables lane i, and any lane that is not enabled outputs zero.
- R3: Throughout the address and data phases, pad_addr_lo carries A0–A7. In 8-bit models pad_addr_mid carries A8–A15, and in 16-bit models it is zero. Both are zero when the bus is idle.
- R4: In the 64 KB models, request bits A16–A23 are never driven on any pin, and the address increment for a split word wraps within 16 bits.
- R5: An accepted request gives one clock of address phase (pad_ale high), then 1+WAIT_CYC clocks of data phase (pad_rd or pad_wr high), then a return to idle. The latch strobe is never high together with a read or write strobe.
- R6: On an 8-bit bus a word request runs as two complete byte cycles. The first moves the low byte at the request address. The second moves the high byte at address+1.
- R7: On a 16-bit bus a word moves in one cycle on both lanes. A byte at an even address uses lane 0 (pad_dq_oe = 01) and a byte at an odd address uses lane 1 (pad_dq_oe = 10).
- R8: During write data phases the enabled lanes drive the write data. During read data phases pad_dq_oe is 00 and pad_dq_out is zero.
- R9: Read data is sampled from the lanes on the clock edge that ends each data phase. Byte reads return their byte in rsp_rdata[7:0] with zero above it. rsp_rdata is cleared when a request is accepted and otherwise holds its value.
- R10: rsp_done is a single-clock pulse in the clock after the final data phase of a transaction. req_ready is high only when the bus is idle, and a request presented while the bus is busy is ignored.
- R11: After reset the bus is idle with req_ready high and every strobe, output enable and rsp_done low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wide | input | 1 | Static data width select, 1 = 16-bit bus |
| cfg_big | input | 1 | Static space select, 1 = 16 MB |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_addr | input | 24 | Request byte address |
| req_wdata | input | 16 | Write data, low byte in bits 7:0 |
| req_ready | output | 1 | Bus idle, request accepted this clock if valid |
| rsp_done | output | 1 | Transaction complete pulse |
| rsp_rdata | output | 16 | Read result |
| pad_addr_lo | output | 8 | Dedicated A0–A7 pins |
| pad_addr_mid | output | 8 | Dedicated A8–A15 pins (8-bit models) |
| pad_ale | output | 1 | Address latch enable |
| pad_rd | output | 1 | Read strobe, active high |
| pad_wr | output | 1 | Write strobe, active high |
| pad_dq_out | output | 16 | Data pin output values |
| pad_dq_oe | output | 2 | Per-lane output enable |
| pad_dq_in | input | 16 | Data pin input values |

## Verification
The embedded properties watch, on every clock, the rules that hold regardless of the address: the latch strobe never overlaps a data strobe, and a falling strobe always opens a data phase. They also check that reads never drive the pins, that the minimum model never enables a lane during the address phase, that the completion pulse lasts one clock and comes only with the bus idle, and that accepted requests start an address phase at once. The address-to-lane mapping of each model, the two-cycle word split with its 16-bit wrap, the odd/even lane choice and the assembled read data all depend on particular operands. Only the bench's directed scenarios show these, by comparing every phase of each transaction against values worked out from the requirements.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    // encoding is {wide, big}
    typedef enum logic [1:0] {
        MDL_MIN   = 2'b00,
        MDL_MED_A = 2'b01,
        MDL_MED_B = 2'b10,
        MDL_MAX   = 2'b11
    } model_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_ADDR = 2'b01,
        PH_DATA = 2'b10
    } phase_e;
endpackage

// File: rtl/xbus_model_dec.sv
module xbus_model_dec
    import xbus_pkg::*;
(
    input  logic   cfg_wide,
    input  logic   cfg_big,
    output model_e model_o
);
    always_comb begin
        unique case ({cfg_wide, cfg_big})
            2'b00:   model_o = MDL_MIN;
            2'b01:   model_o = MDL_MED_A;
            2'b10:   model_o = MDL_MED_B;
            default: model_o = MDL_MAX;
        endcase
    end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int AW       = 24,
    parameter int DW       = 16,
    parameter int WAIT_CYC = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  model_e        mdl_i,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_word,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] dq_in,
    output logic          req_ready,
    output logic          done_o,
    output logic [DW-1:0] rdata_o,
    output phase_e        phase_o,
    output model_e        mdl_o,
    output logic          wr_o,
    output logic          word_o,
    output logic          second_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] wdata_o
);
    localparam int LANE   = DW / 2;
    localparam int SMALLW = 2 * LANE;
    localparam int CW     = (WAIT_CYC > 0) ? $clog2(WAIT_CYC + 1) : 1;

    typedef struct packed {
        phase_e        phase;
        model_e        mdl;
        logic          wr;
        logic          word;
        logic          second;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic [CW-1:0] wcnt;
        logic          done;
    } st_t;

    st_t st_d, st_q;

    function automatic logic [AW-1:0] fit_space(input logic [AW-1:0] a, input logic big);
        logic [AW-1:0] r;
        r = a;
        if (!big) r[AW-1:SMALLW] = '0;
        return r;
    endfunction

    logic narrow_q, big_q, last_wait;
    assign narrow_q  = ~st_q.mdl[1];
    assign big_q     = st_q.mdl[0];
    assign last_wait = (st_q.wcnt == CW'(WAIT_CYC));

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.phase  = PH_ADDR;
                    st_d.mdl    = mdl_i;
                    st_d.wr     = req_write;
                    st_d.word   = req_word;
                    st_d.second = 1'b0;
                    st_d.addr   = fit_space(req_addr, mdl_i[0]);
                    st_d.wdata  = req_wdata;
                    st_d.rdata  = '0;
                    st_d.wcnt   = '0;
                end
            end
            PH_ADDR: begin
                st_d.phase = PH_DATA;
                st_d.wcnt  = '0;
            end
            PH_DATA: begin
                if (!last_wait) begin
                    st_d.wcnt = st_q.wcnt + CW'(1);
                end else begin
                    if (!st_q.wr) begin
                        if (narrow_q) begin
                            if (st_q.second) st_d.rdata[DW-1:LANE] = dq_in[LANE-1:0];
                            else             st_d.rdata[LANE-1:0]  = dq_in[LANE-1:0];
                        end else if (st_q.word) begin
                            st_d.rdata = dq_in;
                        end else begin
                            st_d.rdata = {{LANE{1'b0}},
                                          st_q.addr[0] ? dq_in[DW-1:LANE] : dq_in[LANE-1:0]};
                        end
                    end
                    if (narrow_q && st_q.word && !st_q.second) begin
                        st_d.second = 1'b1;
                        st_d.addr   = fit_space(st_q.addr + AW'(1), big_q);
                        st_d.phase  = PH_ADDR;
                    end else begin
                        st_d.phase = PH_IDLE;
                        st_d.done  = 1'b1;
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, mdl: MDL_MIN, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = (st_q.phase == PH_IDLE);
    assign done_o    = st_q.done;
    assign rdata_o   = st_q.rdata;
    assign phase_o   = st_q.phase;
    assign mdl_o     = st_q.mdl;
    assign wr_o      = st_q.wr;
    assign word_o    = st_q.word;
    assign second_o  = st_q.second;
    assign addr_o    = st_q.addr;
    assign wdata_o   = st_q.wdata;

    // R10: completion is a single-clock pulse
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R10: completion only reported with the bus back to idle
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> req_ready);
    // R5: accepted request enters the address phase on the next clock
    p_accept_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (phase_o == PH_ADDR));
    // R5: the address phase always leads straight into a data phase
    p_addr_to_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_ADDR) |=> (phase_o == PH_DATA));
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
    import xbus_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input  phase_e          phase_i,
    input  model_e          mdl_i,
    input  logic            wr_i,
    input  logic            word_i,
    input  logic            second_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [DW-1:0]   wdata_i,
    output logic [DW/2-1:0] addr_lo,
    output logic [DW/2-1:0] addr_mid,
    output logic            ale,
    output logic            rd,
    output logic            wr,
    output logic [DW-1:0]   dq_out,
    output logic [1:0]      dq_oe
);
    localparam int LANE = DW / 2;

    logic [LANE-1:0] a_mid, a_high, w_lo, w_hi;
    logic [LANE-1:0] lane_val [2];
    logic            active;

    assign a_mid  = addr_i[2*LANE-1:LANE];
    assign a_high = addr_i[AW-1:2*LANE];
    assign w_lo   = wdata_i[LANE-1:0];
    assign w_hi   = wdata_i[DW-1:LANE];
    assign active = (phase_i != PH_IDLE);

    assign ale = (phase_i == PH_ADDR);
    assign rd  = (phase_i == PH_DATA) && !wr_i;
    assign wr  = (phase_i == PH_DATA) &&  wr_i;

    assign addr_lo  = active ? addr_i[LANE-1:0] : '0;
    assign addr_mid = (active && !mdl_i[1]) ? a_mid : '0;

    always_comb begin
        lane_val[0] = '0;
        lane_val[1] = '0;
        dq_oe       = 2'b00;
        if (phase_i == PH_ADDR) begin
            unique case (mdl_i)
                MDL_MED_A: begin lane_val[0] = a_high; dq_oe = 2'b01; end
                MDL_MED_B: begin lane_val[0] = a_mid;  dq_oe = 2'b01; end
                MDL_MAX:   begin lane_val[0] = a_mid; lane_val[1] = a_high; dq_oe = 2'b11; end
                default:   dq_oe = 2'b00;
            endcase
        end else if (phase_i == PH_DATA && wr_i) begin
            if (!mdl_i[1]) begin
                lane_val[0] = second_i ? w_hi : w_lo;
                dq_oe       = 2'b01;
            end else if (word_i) begin
                lane_val[0] = w_lo;
                lane_val[1] = w_hi;
                dq_oe       = 2'b11;
            end else if (addr_i[0]) begin
                lane_val[1] = w_lo;
                dq_oe       = 2'b10;
            end else begin
                lane_val[0] = w_lo;
                dq_oe       = 2'b01;
            end
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign dq_out[g*LANE +: LANE] = dq_oe[g] ? lane_val[g] : '0;
    end
endmodule

// File: rtl/xbus_mux_if.sv
module xbus_mux_if
    import xbus_pkg::*;
#(
    parameter int AW       = 24,
    parameter int DW       = 16,
    parameter int WAIT_CYC = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wide,
    input  logic            cfg_big,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic            req_word,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    output logic            req_ready,
    output logic            rsp_done,
    output logic [DW-1:0]   rsp_rdata,
    output logic [DW/2-1:0] pad_addr_lo,
    output logic [DW/2-1:0] pad_addr_mid,
    output logic            pad_ale,
    output logic            pad_rd,
    output logic            pad_wr,
    output logic [DW-1:0]   pad_dq_out,
    output logic [1:0]      pad_dq_oe,
    input  logic [DW-1:0]   pad_dq_in
);
    model_e          mdl_cfg, mdl_cur;
    phase_e          phase;
    logic            cur_wr, cur_word, cur_second;
    logic [AW-1:0]   cur_addr;
    logic [DW-1:0]   cur_wdata;

    xbus_model_dec u_dec (
        .cfg_wide (cfg_wide),
        .cfg_big  (cfg_big),
        .model_o  (mdl_cfg)
    );

    xbus_seq #(.AW(AW), .DW(DW), .WAIT_CYC(WAIT_CYC)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mdl_i     (mdl_cfg),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_word  (req_word),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .dq_in     (pad_dq_in),
        .req_ready (req_ready),
        .done_o    (rsp_done),
        .rdata_o   (rsp_rdata),
        .phase_o   (phase),
        .mdl_o     (mdl_cur),
        .wr_o      (cur_wr),
        .word_o    (cur_word),
        .second_o  (cur_second),
        .addr_o    (cur_addr),
        .wdata_o   (cur_wdata)
    );

    xbus_pins #(.AW(AW), .DW(DW)) u_pins (
        .phase_i  (phase),
        .mdl_i    (mdl_cur),
        .wr_i     (cur_wr),
        .word_i   (cur_word),
        .second_i (cur_second),
        .addr_i   (cur_addr),
        .wdata_i  (cur_wdata),
        .addr_lo  (pad_addr_lo),
        .addr_mid (pad_addr_mid),
        .ale      (pad_ale),
        .rd       (pad_rd),
        .wr       (pad_wr),
        .dq_out   (pad_dq_out),
        .dq_oe    (pad_dq_oe)
    );

    // R5: latch strobe never overlaps a data strobe
    p_ale_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pad_ale |-> !(pad_rd || pad_wr));
    // R5: falling latch strobe opens a data phase
    p_ale_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pad_ale) |-> (pad_rd || pad_wr));
    // R8: reads never drive the data pins
    p_read_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pad_rd |-> (pad_dq_oe == 2'b00));
    // R2: minimum model multiplexes nothing
    p_min_nomux_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_ale && mdl_cur == MDL_MIN) |-> (pad_dq_oe == 2'b00));
    // R4: small-space models never use the upper lane for address
    p_small_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_ale && !mdl_cur[0]) |-> !pad_dq_oe[1]);
    // R11: idle bus drives no strobes
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !(pad_ale || pad_rd || pad_wr));
endmodule

// File: tb/xbus_mux_if_tb_top.sv
`timescale 1ns/1ps
module xbus_mux_if_tb_top;
    localparam int WAIT = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wide = 1'b0, cfg_big = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rsp_done;
    logic [15:0] rsp_rdata;
    logic [7:0]  pad_addr_lo, pad_addr_mid;
    logic        pad_ale, pad_rd, pad_wr;
    logic [15:0] pad_dq_out;
    logic [1:0]  pad_dq_oe;
    logic [15:0] pad_dq_in = '0;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    xbus_mux_if #(.AW(24), .DW(16), .WAIT_CYC(WAIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_big(cfg_big),
        .req_valid(req_valid), .req_write(req_write), .req_word(req_word),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .pad_addr_lo(pad_addr_lo),
        .pad_addr_mid(pad_addr_mid), .pad_ale(pad_ale), .pad_rd(pad_rd),
        .pad_wr(pad_wr), .pad_dq_out(pad_dq_out), .pad_dq_oe(pad_dq_oe),
        .pad_dq_in(pad_dq_in)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // One full transaction checked phase by phase (R2..R10)
    task automatic run_txn(input bit wide, input bit big, input bit wr, input bit word,
                           input logic [23:0] addr, input logic [15:0] wd, input logic [15:0] din);
        int nb;
        logic [23:0] ba;
        logic [15:0] eout, erd;
        logic [1:0]  eoe;
        nb = (!wide && word) ? 2 : 1;
        cfg_wide = wide; cfg_big = big;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_word = word; req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        for (int b = 0; b < nb; b++) begin
            if (big) ba = addr + 24'(b);
            else     ba = {8'h00, addr[15:0] + 16'(b)};
            pad_dq_in = wide ? din : {8'hA5, (b == 1) ? din[15:8] : din[7:0]};
            // address phase
            chk(pad_ale === 1'b1 && pad_rd === 1'b0 && pad_wr === 1'b0, "R5 addr phase strobes",
                {29'd0, pad_ale, pad_rd, pad_wr}, 32'h4);
            chk(pad_addr_lo === ba[7:0], "R3 addr_lo in addr phase", pad_addr_lo, ba[7:0]);
            chk(pad_addr_mid === (wide ? 8'h00 : ba[15:8]), "R3 addr_mid in addr phase",
                pad_addr_mid, wide ? 8'h00 : ba[15:8]);
            case ({wide, big})
                2'b00: begin eoe = 2'b00; eout = 16'h0000; end
                2'b01: begin eoe = 2'b01; eout = {8'h00, ba[23:16]}; end
                2'b10: begin eoe = 2'b01; eout = {8'h00, ba[15:8]}; end
                default: begin eoe = 2'b11; eout = {ba[23:16], ba[15:8]}; end
            endcase
            chk(pad_dq_oe === eoe && pad_dq_out === eout, "R2 R4 mux address on data pins",
                {14'd0, pad_dq_oe, pad_dq_out}, {14'd0, eoe, eout});
            // data phase
            if (!wr) begin eoe = 2'b00; eout = 16'h0000; end
            else if (!wide) begin eoe = 2'b01; eout = {8'h00, (b == 1) ? wd[15:8] : wd[7:0]}; end
            else if (word) begin eoe = 2'b11; eout = wd; end
            else if (addr[0]) begin eoe = 2'b10; eout = {wd[7:0], 8'h00}; end
            else begin eoe = 2'b01; eout = {8'h00, wd[7:0]}; end
            for (int k = 0; k <= WAIT; k++) begin
                @(negedge clk);
                chk(pad_ale === 1'b0 && pad_rd === !wr && pad_wr === wr, "R5 data phase strobes",
                    {29'd0, pad_ale, pad_rd, pad_wr}, {29'd0, 1'b0, !wr, wr});
                chk(pad_addr_lo === ba[7:0], "R3 addr_lo held in data phase", pad_addr_lo, ba[7:0]);
                chk(pad_dq_oe === eoe && pad_dq_out === eout, "R6 R7 R8 data lanes",
                    {14'd0, pad_dq_oe, pad_dq_out}, {14'd0, eoe, eout});
                chk(rsp_done === 1'b0 && req_ready === 1'b0, "R10 busy during data",
                    {30'd0, rsp_done, req_ready}, 32'd0);
            end
            @(negedge clk);
        end
        if (wr) erd = 16'h0000;
        else if (!wide) erd = word ? din : {8'h00, din[7:0]};
        else if (word) erd = din;
        else erd = addr[0] ? {8'h00, din[15:8]} : {8'h00, din[7:0]};
        chk(rsp_done === 1'b1 && req_ready === 1'b1 && pad_ale === 1'b0, "R10 done after last data",
            {29'd0, rsp_done, req_ready, pad_ale}, 32'h6);
        chk(rsp_rdata === erd, "R9 read result", rsp_rdata, erd);
        @(negedge clk);
        chk(rsp_done === 1'b0, "R10 done single pulse", rsp_done, 0);
        chk(rsp_rdata === erd, "R9 result held", rsp_rdata, erd);
    endtask

    task automatic t_reset();
        chk(req_ready === 1'b1 && pad_ale === 1'b0 && pad_rd === 1'b0 && pad_wr === 1'b0,
            "R11 reset strobes", {28'd0, req_ready, pad_ale, pad_rd, pad_wr}, 32'h8);
        chk(pad_dq_oe === 2'b00 && rsp_done === 1'b0, "R11 reset oe/done",
            {29'd0, pad_dq_oe, rsp_done}, 32'd0);
    endtask

    task automatic t_models();
        // R1: all four models on reads and writes
        run_txn(0, 0, 1, 0, 24'h7E_3456, 16'h00C3, 16'h0000);
        run_txn(0, 0, 0, 0, 24'hFF_1234, 16'h0000, 16'h1122);
        run_txn(0, 1, 1, 0, 24'hAB_CD01, 16'h005A, 16'h0000);
        run_txn(0, 1, 0, 0, 24'h5C_0099, 16'h0000, 16'h7733);
        run_txn(1, 0, 1, 1, 24'h9A_4C20, 16'hBEEF, 16'h0000);
        run_txn(1, 0, 0, 1, 24'h11_2232, 16'h0000, 16'hC0DE);
        run_txn(1, 1, 1, 1, 24'h3D_8E40, 16'h1357, 16'h0000);
        run_txn(1, 1, 0, 1, 24'hE2_7F02, 16'h0000, 16'h2468);
    endtask

    task automatic t_split();
        // R6 word split on 8-bit bus, R4 wrap inside 64 KB
        run_txn(0, 0, 1, 1, 24'h42_10A0, 16'hA1B2, 16'h0000);
        run_txn(0, 0, 0, 1, 24'hC3_FFFF, 16'h0000, 16'h9876);
        run_txn(0, 1, 1, 1, 24'h12_FFFF, 16'h5566, 16'h0000);
        run_txn(0, 1, 0, 1, 24'h0F_0040, 16'h0000, 16'hFACE);
    endtask

    task automatic t_wide_bytes();
        // R7 lane choice by address parity
        run_txn(1, 0, 1, 0, 24'h00_1001, 16'h00E7, 16'h0000);
        run_txn(1, 0, 1, 0, 24'h00_1002, 16'h0019, 16'h0000);
        run_txn(1, 1, 0, 0, 24'h44_2003, 16'h0000, 16'hABCD);
        run_txn(1, 1, 0, 0, 24'h44_2004, 16'h0000, 16'hABCD);
    endtask

    task automatic t_busy_ignore();
        // R10: request presented while busy has no effect
        cfg_wide = 1'b1; cfg_big = 1'b1;
        pad_dq_in = 16'h0F0F;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_word = 1'b1; req_addr = 24'h20_3040; req_wdata = '0;
        @(negedge clk);
        req_addr = 24'h77_8899; req_write = 1'b1;
        chk(req_ready === 1'b0 && pad_ale === 1'b1, "R10 busy in addr phase",
            {30'd0, req_ready, pad_ale}, 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        chk(pad_addr_lo === 8'h40 && pad_rd === 1'b1, "R10 busy request ignored",
            {23'd0, pad_rd, pad_addr_lo}, {23'd0, 1'b1, 8'h40});
        for (int k = 0; k < WAIT; k++) @(negedge clk);
        @(negedge clk);
        chk(rsp_done === 1'b1 && rsp_rdata === 16'h0F0F, "R10 R9 first request completes",
            rsp_rdata, 16'h0F0F);
        @(negedge clk);
        chk(pad_ale === 1'b0 && pad_wr === 1'b0 && req_ready === 1'b1, "R10 no second cycle",
            {29'd0, pad_ale, pad_wr, req_ready}, 32'd1);
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_models();
        t_split();
        t_wide_bytes();
        t_busy_ignore();
        repeat (2) @(negedge clk);
        summary();
    end
endmodule